// File: doc/BRIEF.md
# Serial Converter Frame Master with Chip-Select Power Control

This block drives the chip select and serial clock of a two-channel successive-approximation converter whose power state is chosen purely by how many serial clock falling edges occur before chip select is released. A host issues commands through a valid/ready handshake. Each command maps to a fixed frame length. A plain read uses 14 edges and captures one 12-bit result from each of the two data lines. A dual read uses 32 edges and collects both results from data line A. Short frames of five edges put the converter into partial or full power-down. A 14-edge dummy frame wakes it up.

The controller keeps its own copy of the converter's power state, updated when chip select rises. A read result is reported with a one-cycle strobe only when the frame began with the converter awake. A frame that wakes the converter is consumed silently. After every frame a programmable quiet interval passes before the next one can start. A programmable limit raises a flag when the converter has stayed in partial power-down too long.

Top module: `adc_frame_master`

## Requirements
- R1: After reset `adc_cs_n` is 1, `adc_sclk` is 0, `busy` is 0, `cmd_ready` is 1, `rd_valid` is 0, `pd_timeout` is 0 and `pwr_state` is 0. Power encoding: 0 awake, 1 partial power-down, 2 full power-down.
- R2: Command code 0 (read) holds `adc_cs_n` low for exactly 14 serial clock falling edges. Serial bits are numbered from 0, where bit 0 is the one present when chip select falls and bit k follows falling edge k. `rd_a` takes bits 2..13 of line A and `rd_b` takes bits 2..13 of line B, MSB first. `rd_valid` pulses for one cycle with `rd_dual`=0.
- R3: Command code 1 (dual read) holds chip select low for exactly 32 falling edges. `rd_a` takes bits 2..13 of line A and `rd_b` takes bits 18..29 of line A. `rd_valid` pulses with `rd_dual`=1.
- R4: The serial clock idles low while chip select is high. Each clock phase lasts `half_div` system cycles, with 0 treated as 1. Data lines are sampled on the rising edge, opposite to the falling edge on which the converter changes them.
- R5: Command code 2 issues a 5-edge frame. The power state moves from 0 to 1, from 1 to 2, and stays at 2.
- R6: Command code 3 ends in state 2. From state 0 it runs two 5-edge frames back to back without further handshakes; from state 1 it runs one.
- R7: Command code 4, and the unused codes 5 to 7, issue a 14-edge wake frame. It sets the state to 0 and produces no `rd_valid`.
- R8: A read or dual read that starts in state 1 or 2 keeps its full length and sets the state to 0, but produces no `rd_valid`.
- R9: `busy` is high from chip select falling until the quiet interval ends. Chip select then stays high for `quiet_len`+1 cycles while `busy` stays high. `cmd_ready` is low while `busy` is high.
- R10: `pd_timeout` goes high once the state has been 1 for `pd_limit` cycles, and drops when the state leaves 1.
- R11: A command is taken only when `cmd_valid` and `cmd_ready` are both high. A command offered while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Controller can take a command |
| cmd_op | input | 3 | Command code |
| half_div | input | DIV_W | System cycles per serial clock phase |
| quiet_len | input | QUIET_W | Quiet interval length after each frame |
| pd_limit | input | TMO_W | Partial power-down dwell limit in cycles |
| adc_cs_n | output | 1 | Converter chip select, active low |
| adc_sclk | output | 1 | Converter serial clock |
| adc_sd_a | input | 1 | Converter data line A |
| adc_sd_b | input | 1 | Converter data line B |
| rd_valid | output | 1 | One-cycle result strobe |
| rd_dual | output | 1 | Result came from a dual read |
| rd_a | output | 12 | Channel A result |
| rd_b | output | 12 | Channel B result |
| busy | output | 1 | Frame or quiet interval in progress |
| pwr_state | output | 2 | Tracked converter power state |
| pd_timeout | output | 1 | Partial power-down dwell exceeded |

## Verification
The bench models the converter as a shifter driven by falling edges and counts the edges in every frame. An off-by-one frame length would leave the converter in the wrong power mode, and it shows up directly as a wrong edge count. The bench also runs reads that start from either power-down state. A controller that did not track the power state would report a stale result from such a frame. It would also miss the second short frame that full power-down needs from the awake state. Further directed cases cover:
- the phase width with a divider above one;
- the exact length of the quiet gap;
- a command offered while busy, which must not change the frame in progress;
- the dwell-limit flag, both rising and clearing.

// File: rtl/adc_frame_master.sv
`timescale 1ns/1ps
module adc_frame_master #(
  parameter int DIV_W       = 8,
  parameter int QUIET_W     = 8,
  parameter int TMO_W       = 16,
  parameter int SHORT_EDGES = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_valid,
  output logic               cmd_ready,
  input  logic [2:0]         cmd_op,
  input  logic [DIV_W-1:0]   half_div,
  input  logic [QUIET_W-1:0] quiet_len,
  input  logic [TMO_W-1:0]   pd_limit,
  output logic               adc_cs_n,
  output logic               adc_sclk,
  input  logic               adc_sd_a,
  input  logic               adc_sd_b,
  output logic               rd_valid,
  output logic               rd_dual,
  output logic [11:0]        rd_a,
  output logic [11:0]        rd_b,
  output logic               busy,
  output logic [1:0]         pwr_state,
  output logic               pd_timeout
);
  localparam int LONG_EDGES = 32;
  localparam int READ_EDGES = 14;
  localparam int HW = $clog2(2 * LONG_EDGES + 1);
  localparam int BW = HW - 1;

  localparam logic [2:0] OP_READ = 3'd0;
  localparam logic [2:0] OP_DUAL = 3'd1;
  localparam logic [2:0] OP_PART = 3'd2;
  localparam logic [2:0] OP_FULL = 3'd3;

  localparam logic [1:0] P_AWAKE = 2'd0;
  localparam logic [1:0] P_PART  = 2'd1;
  localparam logic [1:0] P_FULL  = 2'd2;

  typedef enum logic [1:0] {S_IDLE, S_FRAME, S_QUIET} st_t;

  st_t              st;
  logic [DIV_W-1:0] dcnt;
  logic [HW-1:0]    hcnt;
  logic [2:0]       op_q;
  logic [1:0]       pw_q;
  logic             cs_q, sclk_q, chain_q;
  logic [QUIET_W-1:0] qcnt;
  logic [11:0]      sh_a, sh_b;
  logic [TMO_W-1:0] tcnt;

  logic             op_short, op_read, op_dual, tick;
  logic [HW-1:0]    half_target;
  logic [DIV_W:0]   half_eff;
  logic [BW-1:0]    bidx;
  logic             in_first, in_second;

  assign op_short    = (op_q == OP_PART) || (op_q == OP_FULL);
  assign op_dual     = (op_q == OP_DUAL);
  assign op_read     = (op_q == OP_READ) || op_dual;
  assign half_target = op_short ? HW'(2 * SHORT_EDGES)
                     : op_dual  ? HW'(2 * LONG_EDGES)
                                : HW'(2 * READ_EDGES);
  assign half_eff    = (half_div == '0) ? (DIV_W+1)'(1) : {1'b0, half_div};
  assign tick        = (st == S_FRAME) && ({1'b0, dcnt} + 1'b1 >= half_eff);
  assign bidx        = hcnt[HW-1:1];
  assign in_first    = (bidx >= BW'(2))  && (bidx <= BW'(13));
  assign in_second   = (bidx >= BW'(18)) && (bidx <= BW'(29));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      dcnt     <= '0;
      hcnt     <= '0;
      op_q     <= '0;
      pw_q     <= P_AWAKE;
      cs_q     <= 1'b1;
      sclk_q   <= 1'b0;
      chain_q  <= 1'b0;
      qcnt     <= '0;
      sh_a     <= '0;
      sh_b     <= '0;
      rd_valid <= 1'b0;
      rd_dual  <= 1'b0;
      rd_a     <= '0;
      rd_b     <= '0;
    end else begin
      rd_valid <= 1'b0;
      case (st)
        S_IDLE: if (cmd_valid) begin
          op_q    <= cmd_op;
          chain_q <= (cmd_op == OP_FULL) && (pw_q == P_AWAKE);
          cs_q    <= 1'b0;
          dcnt    <= '0;
          hcnt    <= '0;
          st      <= S_FRAME;
        end
        S_FRAME: if (tick) begin
          dcnt <= '0;
          if (hcnt == half_target) begin
            cs_q <= 1'b1;
            qcnt <= '0;
            st   <= S_QUIET;
            if (op_read && pw_q == P_AWAKE) begin
              rd_valid <= 1'b1;
              rd_dual  <= op_dual;
              rd_a     <= sh_a;
              rd_b     <= sh_b;
            end
            if (op_short) pw_q <= (pw_q == P_AWAKE) ? P_PART : P_FULL;
            else          pw_q <= P_AWAKE;
          end else begin
            hcnt <= hcnt + 1'b1;
            if (!hcnt[0]) begin
              sclk_q <= 1'b1;
              if (in_first) begin
                sh_a <= {sh_a[10:0], adc_sd_a};
                if (!op_dual) sh_b <= {sh_b[10:0], adc_sd_b};
              end else if (in_second && op_dual) begin
                sh_b <= {sh_b[10:0], adc_sd_a};
              end
            end else begin
              sclk_q <= 1'b0;
            end
          end
        end else begin
          dcnt <= dcnt + 1'b1;
        end
        S_QUIET: if (qcnt >= quiet_len) begin
          if (chain_q) begin
            chain_q <= 1'b0;
            cs_q    <= 1'b0;
            dcnt    <= '0;
            hcnt    <= '0;
            st      <= S_FRAME;
          end else begin
            st <= S_IDLE;
          end
        end else begin
          qcnt <= qcnt + 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                tcnt <= '0;
    else if (pw_q != P_PART)   tcnt <= '0;
    else if (tcnt != '1)       tcnt <= tcnt + 1'b1;
  end

  assign cmd_ready  = (st == S_IDLE);
  assign busy       = (st != S_IDLE);
  assign adc_cs_n   = cs_q;
  assign adc_sclk   = sclk_q;
  assign pwr_state  = pw_q;
  assign pd_timeout = (pw_q == P_PART) && (tcnt >= pd_limit);
endmodule

// File: rtl/adc_frame_master_chk.sv
`timescale 1ns/1ps
module adc_frame_master_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_valid,
  input logic       cmd_ready,
  input logic       adc_cs_n,
  input logic       adc_sclk,
  input logic       rd_valid,
  input logic       busy,
  input logic [1:0] pwr_state,
  input logic       pd_timeout
);
  a_r4_sclk_idle: assert property (@(posedge clk) disable iff (!rst_n)
    adc_cs_n |-> !adc_sclk);
  a_r9_busy_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
    !adc_cs_n |-> busy);
  a_r9_cs_gap: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(adc_cs_n) |=> adc_cs_n);
  a_r11_accept_starts: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> !adc_cs_n);
  a_r2_strobe_once: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);
  a_r3_strobe_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $rose(adc_cs_n));
  a_r8_strobe_awake: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> (pwr_state == 2'd0));
  a_r5_state_legal: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_state != 2'd3);
  a_r10_no_flag_awake: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_state == 2'd0) |-> !pd_timeout);
endmodule

bind adc_frame_master adc_frame_master_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .adc_cs_n(adc_cs_n), .adc_sclk(adc_sclk), .rd_valid(rd_valid),
  .busy(busy), .pwr_state(pwr_state), .pd_timeout(pd_timeout)
);

// File: tb/test_adc_frame_master.sv
`timescale 1ns/1ps
module test_adc_frame_master;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic [2:0] cmd_op = '0;
  logic [7:0] half_div = 8'd2;
  logic [7:0] quiet_len = 8'd4;
  logic [15:0] pd_limit = 16'd1000;
  logic cmd_ready, adc_cs_n, adc_sclk, adc_sd_a, adc_sd_b;
  logic rd_valid, rd_dual, busy, pd_timeout;
  logic [11:0] rd_a, rd_b;
  logic [1:0] pwr_state;

  always #2.5 clk = ~clk;

  adc_frame_master i_adc_frame_master (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .half_div(half_div), .quiet_len(quiet_len),
    .pd_limit(pd_limit), .adc_cs_n(adc_cs_n), .adc_sclk(adc_sclk),
    .adc_sd_a(adc_sd_a), .adc_sd_b(adc_sd_b), .rd_valid(rd_valid),
    .rd_dual(rd_dual), .rd_a(rd_a), .rd_b(rd_b), .busy(busy),
    .pwr_state(pwr_state), .pd_timeout(pd_timeout)
  );

  // converter model: bit k follows falling edge k
  logic [11:0] va = '0, vb = '0;
  int bidx = 0, last_falls = 0, nframes = 0;
  always @(negedge adc_sclk or posedge adc_cs_n) begin
    if (adc_cs_n) begin
      if (bidx != 0) begin
        last_falls <= bidx;
        nframes <= nframes + 1;
      end
      bidx <= 0;
    end else begin
      bidx <= bidx + 1;
    end
  end
  assign adc_sd_a = (bidx >= 2 && bidx <= 13) ? va[13 - bidx]
                  : (bidx >= 18 && bidx <= 29) ? vb[29 - bidx] : 1'b0;
  assign adc_sd_b = (bidx >= 2 && bidx <= 13) ? vb[13 - bidx] : 1'b0;

  int nvalid = 0;
  logic [11:0] got_a = '0, got_b = '0;
  logic got_dual = 1'b0;
  always @(negedge clk) if (rd_valid) begin
    nvalid <= nvalid + 1;
    got_a <= rd_a;
    got_b <= rd_b;
    got_dual <= rd_dual;
  end

  int nchk = 0, nfail = 0;
  bit done = 1'b0;
  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic run_cmd(input logic [2:0] op);
    int guard;
    guard = 0;
    do @(negedge clk); while (busy && guard++ < 20000);
    cmd_valid = 1'b1;
    cmd_op = op;
    @(negedge clk);
    cmd_valid = 1'b0;
    guard = 0;
    while (busy && guard++ < 20000) @(negedge clk);
    @(negedge clk);
  endtask

  // {op, a, b, falls, valid, state, frames}
  localparam logic [37:0] VEC [15] = '{
    {3'd0, 12'hABC, 12'h123, 6'd14, 1'b1, 2'd0, 2'd1},
    {3'd1, 12'h5A5, 12'hF0F, 6'd32, 1'b1, 2'd0, 2'd1},
    {3'd0, 12'hFFF, 12'h000, 6'd14, 1'b1, 2'd0, 2'd1},
    {3'd2, 12'h000, 12'h000, 6'd5,  1'b0, 2'd1, 2'd1},
    {3'd0, 12'h111, 12'h222, 6'd14, 1'b0, 2'd0, 2'd1},
    {3'd2, 12'h000, 12'h000, 6'd5,  1'b0, 2'd1, 2'd1},
    {3'd2, 12'h000, 12'h000, 6'd5,  1'b0, 2'd2, 2'd1},
    {3'd4, 12'h000, 12'h000, 6'd14, 1'b0, 2'd0, 2'd1},
    {3'd3, 12'h000, 12'h000, 6'd5,  1'b0, 2'd2, 2'd2},
    {3'd6, 12'h000, 12'h000, 6'd14, 1'b0, 2'd0, 2'd1},
    {3'd1, 12'h800, 12'h001, 6'd32, 1'b1, 2'd0, 2'd1},
    {3'd2, 12'h000, 12'h000, 6'd5,  1'b0, 2'd1, 2'd1},
    {3'd3, 12'h000, 12'h000, 6'd5,  1'b0, 2'd2, 2'd1},
    {3'd1, 12'h3C3, 12'h7E1, 6'd32, 1'b0, 2'd0, 2'd1},
    {3'd0, 12'h000, 12'hFFF, 6'd14, 1'b1, 2'd0, 2'd1}
  };

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      chk(1'b0, "watchdog", 0, 1);
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end

  initial begin
    int f0, v0, cnt;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(adc_cs_n === 1'b1 && adc_sclk === 1'b0, "R1 pins", {adc_cs_n, adc_sclk}, 2);
    chk(busy === 1'b0 && cmd_ready === 1'b1, "R1 handshake", {busy, cmd_ready}, 1);
    chk(rd_valid === 1'b0 && pd_timeout === 1'b0 && pwr_state === 2'd0,
        "R1 status", {rd_valid, pd_timeout, pwr_state}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 R3 R5 R6 R7 R8 vector walk
    for (int i = 0; i < 15; i++) begin
      va = VEC[i][34:23];
      vb = VEC[i][22:11];
      f0 = nframes;
      v0 = nvalid;
      run_cmd(VEC[i][37:35]);
      chk(last_falls == int'(VEC[i][10:5]), $sformatf("R2/R3/R5 edges v%0d", i),
          last_falls, VEC[i][10:5]);
      chk(pwr_state == VEC[i][3:2], $sformatf("R5/R6/R7/R8 state v%0d", i),
          pwr_state, VEC[i][3:2]);
      chk(nframes - f0 == int'(VEC[i][1:0]), $sformatf("R6 frames v%0d", i),
          nframes - f0, VEC[i][1:0]);
      chk(nvalid - v0 == int'(VEC[i][4]), $sformatf("R7/R8 strobes v%0d", i),
          nvalid - v0, VEC[i][4]);
      if (VEC[i][4]) begin
        chk(got_a == va, $sformatf("R2/R3 rd_a v%0d", i), got_a, va);
        chk(got_b == vb, $sformatf("R2/R3 rd_b v%0d", i), got_b, vb);
        chk(got_dual == (VEC[i][37:35] == 3'd1), $sformatf("R3 rd_dual v%0d", i),
            got_dual, VEC[i][37:35] == 3'd1);
      end
    end

    // R4 phase width with divider 3
    half_div = 8'd3;
    va = 12'h9A6; vb = 12'h65B;
    fork
      run_cmd(3'd0);
      begin
        cnt = 0;
        do @(negedge clk); while (adc_cs_n);
        while (!adc_cs_n) begin
          if (adc_sclk) cnt++;
          @(negedge clk);
        end
      end
    join
    chk(cnt == 42, "R4 sclk high cycles", cnt, 42);
    chk(got_a == 12'h9A6 && got_b == 12'h65B, "R4 rising-edge sample", got_a, 12'h9A6);
    half_div = 8'd2;

    // R9 quiet gap
    quiet_len = 8'd7;
    fork
      run_cmd(3'd0);
      begin
        cnt = 0;
        do @(negedge clk); while (adc_cs_n);
        while (!adc_cs_n) begin
          if (cmd_ready) cnt = cnt + 1000;
          @(negedge clk);
        end
        while (busy) begin
          if (adc_cs_n) cnt++;
          @(negedge clk);
        end
      end
    join
    chk(cnt == 8, "R9 quiet cycles and ready low", cnt, 8);
    quiet_len = 8'd4;

    // R11 command offered while busy is ignored
    f0 = nframes;
    v0 = nvalid;
    va = 12'h0F0; vb = 12'hC3C;
    fork
      run_cmd(3'd0);
      begin
        repeat (6) @(negedge clk);
        cmd_op = 3'd2;
        cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
      end
    join
    chk(last_falls == 14 && nframes - f0 == 1, "R11 frame unchanged", last_falls, 14);
    chk(pwr_state == 2'd0 && nvalid - v0 == 1, "R11 state unchanged", pwr_state, 0);
    chk(got_a == 12'h0F0 && got_b == 12'hC3C, "R11 data", got_b, 12'hC3C);

    // R10 dwell limit
    pd_limit = 16'd50;
    run_cmd(3'd2);
    chk(pd_timeout == 1'b0, "R10 flag low early", pd_timeout, 0);
    repeat (60) @(negedge clk);
    chk(pd_timeout == 1'b1 && pwr_state == 2'd1, "R10 flag high", pd_timeout, 1);
    run_cmd(3'd4);
    chk(pd_timeout == 1'b0 && pwr_state == 2'd0, "R10 flag cleared", pd_timeout, 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule